// File: doc/BRIEF.md
# Interrupt Mask Duration Monitor

This block measures how long a processor keeps its interrupt mask bits set. It runs its own free-running cycle counter. For each watched mask bit it records the cycle at which the bit was first seen set. When the bit is seen clear again, it works out the length of that interval. It keeps the shortest and the longest completed intervals for each bit. Channel 0 watches the ordinary interrupt mask and channel 1 watches the non-maskable-request mask. The two channels share nothing except the counter and the control strobes.

The mask bits are sampled only on cycles where the instruction-boundary strobe is high. A one-cycle report request makes the block return, for every channel, a minimum and a maximum on the cycle after the request:
- If an interval is still open at the request, the time elapsed so far counts toward the maximum, and that extension is also kept in the stored maximum.
- If no interval has completed since reset or clear, the reported minimum is replaced by the reported maximum.

A synchronous clear returns all statistics to their reset values and leaves the counter running.

Top module: `mask_span_monitor`

## Requirements
- R1: `cycle_count` is 0 during reset and rises by one on every clock after reset, modulo 2^CNT_W. `stats_clr` has no effect on it.
- R2: On a clock where `insn_strobe` is high, a channel's mask bit is 1 and that channel has no open interval, the channel latches the current `cycle_count` as its start and marks the interval open.
- R3: On a clock where `insn_strobe` is high, a channel's mask bit is 0 and its interval is open, the duration is `cycle_count` minus the start, modulo 2^CNT_W. The interval is then closed.
- R4: A closing duration replaces the stored minimum if it is smaller and the stored maximum if it is larger.
- R5: After reset every channel has its minimum at all ones, its maximum at 0, and no open interval.
- R6: When `report_req` is high while a channel's interval is open, the elapsed time (`cycle_count` minus start) raises both the reported maximum and the stored maximum if it is larger. It never changes the minimum.
- R7: When a channel's stored minimum is all ones at the request, its reported minimum equals its reported maximum.
- R8: Each channel keeps its own start, open flag, minimum and maximum. Activity on one channel never changes another channel's report.
- R9: Mask bits are ignored on clocks where `insn_strobe` is low.
- R10: `stats_clr` returns every channel to the R5 state. It takes priority over strobe and report updates to the stored state. A report requested in the same cycle reflects the state before the clear.
- R11: `rpt_valid` is high exactly on the cycle after each `report_req` cycle. A report reflects the state before that clock's updates. Channel c occupies bits [c*CNT_W +: CNT_W] of `rpt_min` and `rpt_max`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stats_clr | input | 1 | Synchronous clear of all statistics |
| insn_strobe | input | 1 | Instruction-boundary sample strobe |
| mask_bits | input | NUM_CH | Mask bit per channel (0: interrupt mask, 1: request mask) |
| report_req | input | 1 | One-cycle report request |
| cycle_count | output | CNT_W | Free-running cycle counter |
| rpt_valid | output | 1 | Report outputs updated this cycle |
| rpt_min | output | NUM_CH*CNT_W | Reported minimum per channel |
| rpt_max | output | NUM_CH*CNT_W | Reported maximum per channel |

## Verification
The assertions assume that `report_req`, `stats_clr` and `insn_strobe` are plain synchronous levels, judged only at the clock edge. They also assume that an interval shorter than the counter period is the only one whose length has meaning. Longer intervals wrap, and the bench models that wrap rather than avoiding it. The bench drives every input at the falling edge. It runs a small 8-bit counter configuration long enough to wrap the counter many times, and mixes mask toggles, strobes, reports and rare clears across both channels in every combination.

// File: rtl/msm_pkg.sv
package msm_pkg;
  typedef logic [63:0] span_t;

  // elapsed cycles, caller truncates to its counter width for modulo wrap
  function automatic span_t span_of(input span_t now, input span_t start);
    return now - start;
  endfunction

  function automatic span_t pick_min(input span_t a, input span_t b);
    return (b < a) ? b : a;
  endfunction

  function automatic span_t pick_max(input span_t a, input span_t b);
    return (b > a) ? b : a;
  endfunction

  // reported minimum falls back to the reported maximum while untouched
  function automatic span_t floor_min(input span_t mn, input span_t mx, input span_t empty);
    return (mn == empty) ? mx : mn;
  endfunction
endpackage

// File: rtl/msm_cycle_counter.sv
module msm_cycle_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= count_o + 1'b1;
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count_o == CNT_W'($past(count_o) + 1'b1));
endmodule

// File: rtl/msm_span_tracker.sv
module msm_span_tracker #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             strobe_i,
  input  logic             mask_i,
  input  logic             report_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             open_o,
  output logic [CNT_W-1:0] elapsed_o,
  output logic [CNT_W-1:0] min_o,
  output logic [CNT_W-1:0] max_o
);
  import msm_pkg::*;

  localparam logic [CNT_W-1:0] EMPTY_MIN = '1;

  logic [CNT_W-1:0] start_q;
  logic             open_evt;
  logic             close_evt;
  logic             stretch_evt;
  logic [CNT_W-1:0] min_cand;
  logic [CNT_W-1:0] max_cand;

  assign open_evt    = strobe_i & mask_i & ~open_o;
  assign close_evt   = strobe_i & ~mask_i & open_o;
  assign stretch_evt = report_i & open_o & ~close_evt;
  assign elapsed_o   = CNT_W'(span_of(64'(cnt_i), 64'(start_q)));
  assign min_cand    = CNT_W'(pick_min(64'(min_o), 64'(elapsed_o)));
  assign max_cand    = CNT_W'(pick_max(64'(max_o), 64'(elapsed_o)));

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      start_q <= '0;
      open_o  <= 1'b0;
      min_o   <= EMPTY_MIN;
      max_o   <= '0;
    end else begin
      if (open_evt) begin
        start_q <= cnt_i;
        open_o  <= 1'b1;
      end
      if (close_evt) begin
        open_o <= 1'b0;
        min_o  <= min_cand;
        max_o  <= max_cand;
      end else if (stretch_evt) begin
        max_o <= max_cand;
      end
    end
  end

  assert_open_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && mask_i && !open_o && !clr_i) |=> (open_o && start_q == $past(cnt_i)));
  assert_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !mask_i && open_o && !clr_i) |=> !open_o);
  assert_max_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> max_o >= $past(max_o));
  assert_min_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> min_o <= $past(min_o));
  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (min_o != EMPTY_MIN) |-> max_o >= min_o);
  assert_ignore_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !clr_i) |=> (open_o == $past(open_o) && min_o == $past(min_o)));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (min_o == EMPTY_MIN && max_o == '0 && !open_o));
endmodule

// File: rtl/msm_report_stage.sv
module msm_report_stage #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             report_i,
  input  logic             open_i,
  input  logic [CNT_W-1:0] elapsed_i,
  input  logic [CNT_W-1:0] min_i,
  input  logic [CNT_W-1:0] max_i,
  output logic [CNT_W-1:0] rpt_min_o,
  output logic [CNT_W-1:0] rpt_max_o
);
  import msm_pkg::*;

  localparam logic [CNT_W-1:0] EMPTY_MIN = '1;

  logic [CNT_W-1:0] max_view;
  logic [CNT_W-1:0] min_view;

  assign max_view = open_i ? CNT_W'(pick_max(64'(max_i), 64'(elapsed_i))) : max_i;
  assign min_view = CNT_W'(floor_min(64'(min_i), 64'(max_view), 64'(EMPTY_MIN)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpt_min_o <= '0;
      rpt_max_o <= '0;
    end else if (report_i) begin
      rpt_min_o <= min_view;
      rpt_max_o <= max_view;
    end
  end

  assert_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    report_i |=> rpt_max_o >= $past(max_i));
  assert_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (report_i && min_i == EMPTY_MIN) |=> rpt_min_o == rpt_max_o);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !report_i |=> $stable(rpt_max_o) && $stable(rpt_min_o));
endmodule

// File: rtl/mask_span_monitor.sv
module mask_span_monitor #(
  parameter int CNT_W  = 32,
  parameter int NUM_CH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    stats_clr,
  input  logic                    insn_strobe,
  input  logic [NUM_CH-1:0]       mask_bits,
  input  logic                    report_req,
  output logic [CNT_W-1:0]        cycle_count,
  output logic                    rpt_valid,
  output logic [NUM_CH*CNT_W-1:0] rpt_min,
  output logic [NUM_CH*CNT_W-1:0] rpt_max
);
  msm_cycle_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_o (cycle_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rpt_valid <= 1'b0;
    else        rpt_valid <= report_req;
  end

  assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rpt_valid == $past(report_req));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             ch_open;
    logic [CNT_W-1:0] ch_elapsed;
    logic [CNT_W-1:0] ch_min;
    logic [CNT_W-1:0] ch_max;

    msm_span_tracker #(.CNT_W(CNT_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (stats_clr),
      .strobe_i  (insn_strobe),
      .mask_i    (mask_bits[c]),
      .report_i  (report_req),
      .cnt_i     (cycle_count),
      .open_o    (ch_open),
      .elapsed_o (ch_elapsed),
      .min_o     (ch_min),
      .max_o     (ch_max)
    );

    msm_report_stage #(.CNT_W(CNT_W)) u_report (
      .clk       (clk),
      .rst_n     (rst_n),
      .report_i  (report_req),
      .open_i    (ch_open),
      .elapsed_i (ch_elapsed),
      .min_i     (ch_min),
      .max_i     (ch_max),
      .rpt_min_o (rpt_min[c*CNT_W +: CNT_W]),
      .rpt_max_o (rpt_max[c*CNT_W +: CNT_W])
    );

    assert_report_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |-> rpt_min[c*CNT_W +: CNT_W] <= rpt_max[c*CNT_W +: CNT_W]);
  end
endmodule

// File: tb/mask_span_monitor_tb.sv
module mask_span_monitor_tb;
  localparam int W  = 8;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stats_clr = 1'b0;
  logic insn_strobe = 1'b0;
  logic [NC-1:0] mask_bits = '0;
  logic report_req = 1'b0;
  logic [W-1:0] cycle_count;
  logic rpt_valid;
  logic [NC*W-1:0] rpt_min;
  logic [NC*W-1:0] rpt_max;

  int checks = 0;
  int errors = 0;

  // bench model, per channel
  logic         m_open [NC];
  logic [W-1:0] m_start[NC];
  logic [W-1:0] m_min  [NC];
  logic [W-1:0] m_max  [NC];
  logic [W-1:0] e_min  [NC];
  logic [W-1:0] e_max  [NC];

  always #5 clk = ~clk;

  mask_span_monitor #(.CNT_W(W), .NUM_CH(NC)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .stats_clr   (stats_clr),
    .insn_strobe (insn_strobe),
    .mask_bits   (mask_bits),
    .report_req  (report_req),
    .cycle_count (cycle_count),
    .rpt_valid   (rpt_valid),
    .rpt_min     (rpt_min),
    .rpt_max     (rpt_max)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int c = 0; c < NC; c++) begin
      m_open[c] = 1'b0; m_start[c] = '0; m_min[c] = '1; m_max[c] = '0;
    end
  endtask

  // called at a falling edge; applies one clock of stimulus and checks after it
  task automatic step(input logic s, input logic [NC-1:0] m, input logic r,
                      input logic c, input string tag);
    logic [W-1:0] now;
    logic [W-1:0] dur;
    now = cycle_count;
    for (int k = 0; k < NC; k++) begin
      dur = W'(now - m_start[k]);
      e_max[k] = (m_open[k] && dur > m_max[k]) ? dur : m_max[k];
      e_min[k] = (m_min[k] == '1) ? e_max[k] : m_min[k];
    end
    if (c) model_clear();
    else begin
      for (int k = 0; k < NC; k++) begin
        dur = W'(now - m_start[k]);
        if (s && m[k] && !m_open[k]) begin
          m_open[k] = 1'b1; m_start[k] = now;
        end else if (s && !m[k] && m_open[k]) begin
          m_open[k] = 1'b0;
          if (dur < m_min[k]) m_min[k] = dur;
          if (dur > m_max[k]) m_max[k] = dur;
        end else if (r && m_open[k] && dur > m_max[k]) begin
          m_max[k] = dur;
        end
      end
    end
    insn_strobe = s; mask_bits = m; report_req = r; stats_clr = c;
    @(negedge clk);
    chk(cycle_count == W'(now + 1), "R1 counter step", int'(cycle_count), int'(W'(now + 1)));
    chk(rpt_valid == r, "R11 valid pulse", int'(rpt_valid), int'(r));
    if (r) begin
      for (int k = 0; k < NC; k++) begin
        chk(rpt_max[k*W +: W] == e_max[k], {tag, " max (R8 channel)"},
            int'(rpt_max[k*W +: W]), int'(e_max[k]));
        chk(rpt_min[k*W +: W] == e_min[k], {tag, " min (R8 channel)"},
            int'(rpt_min[k*W +: W]), int'(e_min[k]));
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    chk(cycle_count == '0, "R1 reset count", int'(cycle_count), 0);
    rst_n = 1'b1;
    // R5: reset state, R7 floor gives min = max = 0
    step(1'b0, 2'b00, 1'b1, 1'b0, "R5");
    // R9: mask set without strobe stays closed
    for (int i = 0; i < 4; i++) step(1'b0, 2'b11, 1'b0, 1'b0, "R9");
    step(1'b0, 2'b11, 1'b1, 1'b0, "R9");
    // R2 open on channel 0, then R6 report while open
    step(1'b1, 2'b01, 1'b0, 1'b0, "R2");
    for (int i = 0; i < 6; i++) step(1'b0, 2'b00, 1'b0, 1'b0, "R9");
    step(1'b0, 2'b01, 1'b1, 1'b0, "R6");
    // R3 close, then R4 report; channel 1 untouched (R8)
    step(1'b1, 2'b00, 1'b0, 1'b0, "R3");
    step(1'b0, 2'b00, 1'b1, 1'b0, "R4");
    // shorter interval lowers min
    step(1'b1, 2'b01, 1'b0, 1'b0, "R2");
    step(1'b1, 2'b00, 1'b1, 1'b0, "R4");
    step(1'b0, 2'b00, 1'b1, 1'b0, "R4");
    // channel 1 only (R8)
    step(1'b1, 2'b10, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 2'b00, 1'b0, 1'b0, "R8");
    step(1'b1, 2'b00, 1'b1, 1'b0, "R8");
    step(1'b0, 2'b00, 1'b1, 1'b0, "R8");
    // R10 clear with report in the same cycle, then report again
    step(1'b1, 2'b11, 1'b0, 1'b0, "R2");
    step(1'b0, 2'b00, 1'b1, 1'b1, "R10");
    step(1'b0, 2'b00, 1'b1, 1'b0, "R10");
    // sweep with wrap of the 8-bit counter
    begin
      logic [NC-1:0] mk;
      mk = '0;
      for (int i = 0; i < 6000; i++) begin
        logic s, r, c;
        for (int k = 0; k < NC; k++) if ($urandom_range(7) == 0) mk[k] = ~mk[k];
        s = ($urandom_range(2) == 0);
        r = ($urandom_range(5) == 0);
        c = ($urandom_range(399) == 0);
        step(s, mk, r, c, "R4 sweep");
      end
    end
    insn_strobe = 1'b0; report_req = 1'b0; stats_clr = 1'b0;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule